// File: doc/BRIEF.md
# I2C Bus Monitor and Address Classifier

This block watches a two-wire I2C bus without ever driving it. Clock and data enter through two-flop synchronisers. Edges on the synchronised lines are decoded into start and stop conditions, and into bit samples taken on each rising clock edge. A bus-busy flag is set by any start and cleared by a stop.

After every start, including a repeated start, the block captures the address frame. That frame is seven address bits sent most significant bit first, then a read/write bit, then an acknowledge bit. When the ninth bit has been sampled, the block presents the following for exactly one cycle: the address, the direction bit, the acknowledge status, and a category code that marks reserved addresses. Any further bits in the same transfer are data bytes. The block ignores them.

A start or stop that appears partway through the address frame is reported as a protocol error. It still takes effect as the start or stop it represents, and the partial frame is thrown away.

Top module: `i2c_bus_monitor`

## Requirements
- R1: After reset, `busy_o` is 0, `frame_valid_o` is 0, `proto_err_o` is 0 and `cat_o` is 0.
- R2: SDA falling while SCL is high gives a one-cycle `start_o` pulse and sets `busy_o`.
- R3: SDA rising while SCL is high gives a one-cycle `stop_o` pulse and clears `busy_o`.
- R4: A start while `busy_o` is 1 is a repeated start. `busy_o` stays 1 and address capture begins again from the first bit.
- R5: Bits are sampled on each rising SCL edge. The first seven bits after a start form `addr_o`, MSB first. The eighth bit is `rw_o`, where 1 means read.
- R6: `ack_o` is 1 when SDA is low on the ninth rising SCL edge, and 0 when it is high.
- R7: `cat_o` encoding is as follows: 0 is an ordinary address, 1 is address 0000000, 2 is address 0000001, and 3 is any address 1111xxx other than 1111111. Address 1111111 gets code 4.
- R8: `frame_valid_o` is high for exactly one cycle per address frame, together with `addr_o`, `rw_o`, `ack_o` and `cat_o`. Bits after the ninth bit of a frame raise no further strobe until the next start.
- R9: A start or stop seen after one to eight bits of the address frame gives a one-cycle `proto_err_o` pulse. It is coincident with the `start_o` or `stop_o` pulse, and the condition takes effect. The aborted frame raises no strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | Bus clock line, asynchronous |
| sda_i | input | 1 | Bus data line, asynchronous |
| busy_o | output | 1 | Bus busy between start and stop |
| start_o | output | 1 | One-cycle pulse on a start condition |
| stop_o | output | 1 | One-cycle pulse on a stop condition |
| frame_valid_o | output | 1 | One-cycle strobe for a completed address frame |
| addr_o | output | 7 | Captured 7-bit address |
| rw_o | output | 1 | Direction bit, 1 means read |
| ack_o | output | 1 | 1 when the ninth bit was low |
| cat_o | output | 3 | Address category code |
| proto_err_o | output | 1 | Pulse on a start or stop that cuts an address frame short |

## Verification
The bench sends frames with random addresses, mixed with the boundary addresses 0000000, 0000001, 1111000, 1111110 and 1111111. A classifier that tested too few high bits, or gave the all-ones address the ordinary extension code, would report the wrong category on these. Repeated starts check that busy does not drop and that capture restarts. A block that kept its old bit count would shift the second address. Data bits after an address frame check that no second strobe appears. Start and stop conditions injected partway through a byte check that the error pulse fires, that the condition still moves the busy flag, and that the truncated frame is never reported.

// File: rtl/i2cmon_pkg.sv
package i2cmon_pkg;
  localparam int ADDR_W  = 7;
  localparam int FRAME_W = ADDR_W + 1;           // address + rw
  localparam int CNT_W   = $clog2(FRAME_W + 2);

  typedef enum logic [2:0] {
    CAT_NORMAL  = 3'd0,
    CAT_GCALL   = 3'd1,
    CAT_CBUS    = 3'd2,
    CAT_EXT     = 3'd3,
    CAT_EXT_ALL = 3'd4
  } cat_e;

  function automatic cat_e classify(input logic [ADDR_W-1:0] a);
    if (a == '0)                          return CAT_GCALL;
    else if (a == ADDR_W'(1))             return CAT_CBUS;
    else if (&a)                          return CAT_EXT_ALL;
    else if (&a[ADDR_W-1:ADDR_W-4])       return CAT_EXT;
    else                                  return CAT_NORMAL;
  endfunction
endpackage

// File: rtl/i2cmon_sync.sv
module i2cmon_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  // idle bus level is high on both lines
  for (genvar w = 0; w < WIDTH; w++) begin : g_bit
    logic [STAGES-1:0] chain_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) chain_q <= '1;
      else         chain_q <= {chain_q[STAGES-2:0], d_i[w]};
    end
    assign q_o[w] = chain_q[STAGES-1];
  end
endmodule

// File: rtl/i2cmon_cond.sv
module i2cmon_cond (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic start_o,
  output logic stop_o,
  output logic sample_o,
  output logic bit_o
);
  logic scl_q, sda_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_i;
      sda_q <= sda_i;
    end
  end

  // conditions need SCL held high across the SDA transition
  assign start_o  = scl_i & scl_q &  sda_q & ~sda_i;
  assign stop_o   = scl_i & scl_q & ~sda_q &  sda_i;
  assign sample_o = scl_i & ~scl_q;
  assign bit_o    = sda_i;
endmodule

// File: rtl/i2cmon_frame.sv
module i2cmon_frame
  import i2cmon_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic              sample_i,
  input  logic              bit_i,
  output logic              busy_o,
  output logic              start_o,
  output logic              stop_o,
  output logic              valid_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic              rw_o,
  output logic              ack_o,
  output cat_e              cat_o,
  output logic              err_o
);
  localparam logic [CNT_W-1:0] ACK_IDX = CNT_W'(FRAME_W);

  logic               capt_q;
  logic [CNT_W-1:0]   cnt_q;
  logic [FRAME_W-1:0] sh_q;
  logic               mid_frame;

  assign mid_frame = capt_q && (cnt_q != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_o  <= 1'b0;
      start_o <= 1'b0;
      stop_o  <= 1'b0;
      valid_o <= 1'b0;
      err_o   <= 1'b0;
      addr_o  <= '0;
      rw_o    <= 1'b0;
      ack_o   <= 1'b0;
      cat_o   <= CAT_NORMAL;
      capt_q  <= 1'b0;
      cnt_q   <= '0;
      sh_q    <= '0;
    end else begin
      start_o <= start_i;
      stop_o  <= stop_i;
      valid_o <= 1'b0;
      err_o   <= 1'b0;
      if (start_i) begin
        busy_o <= 1'b1;
        capt_q <= 1'b1;
        cnt_q  <= '0;
        err_o  <= mid_frame;
      end else if (stop_i) begin
        busy_o <= 1'b0;
        capt_q <= 1'b0;
        cnt_q  <= '0;
        err_o  <= mid_frame;
      end else if (sample_i && capt_q) begin
        if (cnt_q == ACK_IDX) begin
          capt_q  <= 1'b0;
          cnt_q   <= '0;
          valid_o <= 1'b1;
          addr_o  <= sh_q[FRAME_W-1:1];
          rw_o    <= sh_q[0];
          ack_o   <= ~bit_i;
          cat_o   <= classify(sh_q[FRAME_W-1:1]);
        end else begin
          sh_q  <= {sh_q[FRAME_W-2:0], bit_i};
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/i2c_bus_monitor.sv
module i2c_bus_monitor
  import i2cmon_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              busy_o,
  output logic              start_o,
  output logic              stop_o,
  output logic              frame_valid_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic              rw_o,
  output logic              ack_o,
  output logic [2:0]        cat_o,
  output logic              proto_err_o
);
  logic [1:0] line_s;
  logic       start_d, stop_d, sample_d, bit_d;
  cat_e       cat_w;

  i2cmon_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({scl_i, sda_i}),
    .q_o   (line_s)
  );

  i2cmon_cond u_cond (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .scl_i   (line_s[1]),
    .sda_i   (line_s[0]),
    .start_o (start_d),
    .stop_o  (stop_d),
    .sample_o(sample_d),
    .bit_o   (bit_d)
  );

  i2cmon_frame u_frame (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start_d),
    .stop_i  (stop_d),
    .sample_i(sample_d),
    .bit_i   (bit_d),
    .busy_o  (busy_o),
    .start_o (start_o),
    .stop_o  (stop_o),
    .valid_o (frame_valid_o),
    .addr_o  (addr_o),
    .rw_o    (rw_o),
    .ack_o   (ack_o),
    .cat_o   (cat_w),
    .err_o   (proto_err_o)
  );

  assign cat_o = cat_w;
endmodule

// File: rtl/i2cmon_checker.sv
module i2cmon_checker (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       busy_o,
  input logic       start_o,
  input logic       stop_o,
  input logic       frame_valid_o,
  input logic [6:0] addr_o,
  input logic [2:0] cat_o,
  input logic       proto_err_o
);
  p_busy_rise_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> start_o);
  p_busy_fall_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> stop_o);
  p_start_holds_busy_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o |-> busy_o);
  p_no_start_and_stop_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(start_o && stop_o));
  p_cat_legal_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cat_o <= 3'd4);
  p_all_ones_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frame_valid_o && cat_o == 3'd4) |-> addr_o == 7'h7F);
  p_strobe_single_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_valid_o |=> !frame_valid_o);
  p_strobe_busy_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_valid_o |-> busy_o);
  p_err_is_cond_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    proto_err_o |-> (start_o || stop_o));
  p_err_no_strobe_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    proto_err_o |-> !frame_valid_o);
endmodule

bind i2c_bus_monitor i2cmon_checker u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .busy_o       (busy_o),
  .start_o      (start_o),
  .stop_o       (stop_o),
  .frame_valid_o(frame_valid_o),
  .addr_o       (addr_o),
  .cat_o        (cat_o),
  .proto_err_o  (proto_err_o)
);

// File: tb/i2c_bus_monitor_tb.sv
`timescale 1ns/1ps
module i2c_bus_monitor_tb_top;
  localparam int H = 6;   // clock cycles per bus half phase

  logic clk = 1'b0, rst_n = 1'b0, scl = 1'b1, sda = 1'b1;
  logic busy, st, sp, vld, rw, ack, err;
  logic [6:0] addr;
  logic [2:0] cat;

  int checks = 0, fails = 0;
  int n_start = 0, n_stop = 0, n_err = 0, n_vld = 0;
  logic [6:0] last_addr;
  logic last_rw, last_ack;
  logic [2:0] last_cat;

  always #2.5 clk = ~clk;

  i2c_bus_monitor dut_i (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl), .sda_i(sda),
    .busy_o(busy), .start_o(st), .stop_o(sp), .frame_valid_o(vld),
    .addr_o(addr), .rw_o(rw), .ack_o(ack), .cat_o(cat), .proto_err_o(err)
  );

  always @(negedge clk) if (rst_n) begin
    if (st)  n_start++;
    if (sp)  n_stop++;
    if (err) n_err++;
    if (vld) begin
      n_vld++;
      last_addr = addr; last_rw = rw; last_ack = ack; last_cat = cat;
    end
  end

  function automatic logic [2:0] exp_cat(input logic [6:0] a);
    if (a == 7'd0) return 3'd1;
    if (a == 7'd1) return 3'd2;
    if (a == 7'h7F) return 3'd4;
    if (a[6:3] == 4'hF) return 3'd3;
    return 3'd0;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_h(); repeat (H) @(posedge clk); #1; endtask

  task automatic bus_start();   // expects scl and sda high
    sda = 1'b0; wait_h();
    scl = 1'b0; wait_h();
  endtask

  task automatic rep_start();   // from scl low
    sda = 1'b1; wait_h();
    scl = 1'b1; wait_h();
    sda = 1'b0; wait_h();
    scl = 1'b0; wait_h();
  endtask

  task automatic bus_stop();    // from scl low
    sda = 1'b0; wait_h();
    scl = 1'b1; wait_h();
    sda = 1'b1; wait_h();
  endtask

  task automatic send_bit(input logic b);
    sda = b;    wait_h();
    scl = 1'b1; wait_h();
    scl = 1'b0; wait_h();
  endtask

  task automatic send_frame(input logic [6:0] a, input logic r, input logic ak);
    for (int i = 6; i >= 0; i--) send_bit(a[i]);
    send_bit(r);
    send_bit(~ak);
  endtask

  task automatic check_frame(input int v0, input logic [6:0] a, input logic r, input logic ak);
    check(n_vld == v0 + 1, "R8", n_vld - v0, 1);
    check(last_addr == a, "R5", last_addr, a);
    check(last_rw == r, "R5", last_rw, r);
    check(last_ack == ak, "R6", last_ack, ak);
    check(last_cat == exp_cat(a), "R7", last_cat, exp_cat(a));
  endtask

  task automatic full_txn(input logic [6:0] a, input logic r, input logic ak, input bit data);
    int v0, s0, p0, e0;
    v0 = n_vld; s0 = n_start; p0 = n_stop; e0 = n_err;
    bus_start();
    check(busy == 1'b1, "R2", busy, 1);
    check(n_start == s0 + 1, "R2", n_start - s0, 1);
    send_frame(a, r, ak);
    check_frame(v0, a, r, ak);
    if (data) begin
      send_frame(7'h55, 1'b0, 1'b1);   // data byte, must be ignored
      check(n_vld == v0 + 1, "R8", n_vld - v0, 1);
    end
    bus_stop();
    check(busy == 1'b0, "R3", busy, 0);
    check(n_stop == p0 + 1, "R3", n_stop - p0, 1);
    check(n_err == e0, "R9", n_err - e0, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    int v0, s0, p0, e0;
    logic [6:0] dir [8];
    void'($urandom(32'd20417));
    repeat (4) @(posedge clk);
    #1;
    check(busy == 1'b0, "R1", busy, 0);
    check(vld == 1'b0, "R1", vld, 0);
    check(err == 1'b0, "R1", err, 0);
    check(cat == 3'd0, "R1", cat, 0);
    rst_n = 1'b1;
    wait_h();
    check(busy == 1'b0 && n_start == 0, "R1", n_start, 0);

    dir = '{7'h00, 7'h01, 7'h78, 7'h7E, 7'h7F, 7'h77, 7'h02, 7'h3C};
    foreach (dir[i]) full_txn(dir[i], i[0], i[1], i[2]);
    for (int k = 0; k < 40; k++)
      full_txn(7'($urandom_range(0, 127)), 1'($urandom_range(0, 1)),
               1'($urandom_range(0, 1)), bit'($urandom_range(0, 1)));

    // R4: repeated start keeps busy and restarts capture
    v0 = n_vld; s0 = n_start;
    bus_start();
    send_frame(7'h2A, 1'b0, 1'b1);
    rep_start();
    check(busy == 1'b1, "R4", busy, 1);
    check(n_start == s0 + 2, "R4", n_start - s0, 2);
    send_frame(7'h7F, 1'b1, 1'b0);
    check(n_vld == v0 + 2, "R4", n_vld - v0, 2);
    check(last_addr == 7'h7F && last_cat == 3'd4, "R4", last_addr, 127);
    bus_stop();

    // R9: stop cut into the address frame
    v0 = n_vld; e0 = n_err; p0 = n_stop;
    bus_start();
    for (int i = 0; i < 4; i++) send_bit(1'b1);
    sda = 1'b0; wait_h();
    scl = 1'b1; wait_h();
    sda = 1'b1; wait_h();
    check(n_err == e0 + 1, "R9", n_err - e0, 1);
    check(n_stop == p0 + 1, "R9", n_stop - p0, 1);
    check(busy == 1'b0, "R9", busy, 0);
    check(n_vld == v0, "R9", n_vld - v0, 0);

    // R9: start cut into the address frame, then a clean frame follows
    v0 = n_vld; e0 = n_err; s0 = n_start;
    bus_start();
    for (int i = 0; i < 3; i++) send_bit(1'b0);
    rep_start();
    check(n_err == e0 + 1, "R9", n_err - e0, 1);
    check(n_start == s0 + 2, "R9", n_start - s0, 2);
    check(busy == 1'b1, "R9", busy, 1);
    check(n_vld == v0, "R9", n_vld - v0, 0);
    send_frame(7'h00, 1'b0, 1'b0);
    check_frame(v0, 7'h00, 1'b0, 1'b0);
    bus_stop();
    check(n_err == e0 + 1, "R9", n_err - e0, 1);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule